// File: doc/BRIEF.md
# Concentrating Switch Element Array

This block is a rectangular grid of two-state switch elements. It merges cells arriving on a set of input rows onto a smaller set of output links, which are the grid's columns. Each row input enters the grid on the west side of column 0. Each column also takes a cell at its top, on the north side of row 0. A cell leaves either at the bottom of a column, where it goes onto an output link, or at the east end of a row, where it is discarded.

Each element compares the cell on its west side with the cell on its north side. If the west cell wants this output group and outranks the north cell, the element toggles. Otherwise it stays crossed.

The grid is combinational. Every clock edge is one cell slot, and all south and east outputs are captured in registers at the end of the slot.

Each element can be forced to the cross state, which is how a faulty element is isolated. Each element also has a fault-injection code that can:
- hold it in the cross state,
- hold it in the toggle state, or
- tie its vertical or horizontal output link to all zeros or all ones.

This lets a test controller exercise fault detection, fault location and reconfiguration.

Top module: `cse_array`

## Requirements
- R1: While rst_ni is low, south_o and east_o are all zeros, whatever is on the inputs.
- R2: A cell is packed as {valid, group, priority[PRIO_W-1:0], payload[DATA_W-1:0]}, with valid as the most significant bit. An element toggles only when its west cell is valid, has group=1, and its north cell is either invalid or has a numerically larger priority. In toggle, the west cell goes south and the north cell goes east. Otherwise the element is in cross: north goes south and west goes east.
- R3: When the north and west cells have equal priority, the element stays in cross, so the north cell keeps the column.
- R4: Row r enters at column 0 through west_i[r*CW +: CW], and column c enters at row 0 through north_i[c*CW +: CW]. Column c leaves the last row on south_o[c*CW +: CW], and row r leaves the last column on east_o[r*CW +: CW]. Outputs change only at the clock edge that ends the slot, so they show the inputs present at that edge.
- R5: With no fault code active, the number of valid cells leaving in a slot equals the number that entered it.
- R6: With no fault code active, if every west cell has group=0, then south_o equals north_i and east_o equals west_i.
- R7: force_cross_i[r*COLS+c]=1 puts element (r,c) in cross. This overrides both its control decision and a toggle-stuck fault.
- R8: Fault code 1 (in fault_code_i[(r*COLS+c)*3 +: 3]) holds the element in cross.
- R9: Fault code 2 holds the element in toggle, even when its west cell is empty.
- R10: Fault codes 3 and 4 force the element's south output link to all zeros and all ones respectively, after routing.
- R11: Fault codes 5 and 6 force the element's east output link to all zeros and all ones respectively, after routing.
- R12: Fault codes 0 and 7 leave the element fault-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one edge per cell slot |
| rst_ni | input | 1 | Active-low asynchronous reset |
| west_i | input | ROWS*CW | Row input cells, row r at [r*CW +: CW] |
| north_i | input | COLS*CW | Column-top cells, column c at [c*CW +: CW] |
| force_cross_i | input | ROWS*COLS | Per-element cross override, element (r,c) at bit r*COLS+c |
| fault_code_i | input | ROWS*COLS*3 | Per-element fault-injection code |
| south_o | output | COLS*CW | Registered output-link cells |
| east_o | output | ROWS*CW | Registered discard cells |

## Verification
The conservation, test-mode and force-cross assertions hold only in slots where no fault code in the range 1 to 6 is active. The force-cross assertion additionally holds only when no stuck-link code is present. Every assertion also assumes the inputs were driven to known values in the slot before the edge it checks.

The bench drives every input from time zero and changes it only one time unit after an edge. It sweeps fault codes one element at a time, so fault-free slots and faulted slots are cleanly separated. Expected outputs come from a slot-level reference walk over the grid, written from the requirements, together with directed cases whose results are worked out by hand.

// File: rtl/cse_pkg.sv
package cse_pkg;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_XSTUCK = 3'd1,
    FLT_TSTUCK = 3'd2,
    FLT_V_LO   = 3'd3,
    FLT_V_HI   = 3'd4,
    FLT_H_LO   = 3'd5,
    FLT_H_HI   = 3'd6,
    FLT_SPARE  = 3'd7
  } fault_e;

  localparam int unsigned FAULT_W = 3;

endpackage

// File: rtl/cse_elem.sv
module cse_elem
  import cse_pkg::*;
#(
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned CW = 2 + PRIO_W + DATA_W
) (
  input  logic [CW-1:0] north_i,
  input  logic [CW-1:0] west_i,
  input  logic          force_cross_i,
  input  fault_e        fault_i,
  output logic [CW-1:0] south_o,
  output logic [CW-1:0] east_o
);
  localparam int unsigned V_BIT  = CW - 1;
  localparam int unsigned G_BIT  = CW - 2;
  localparam int unsigned P_HI   = CW - 3;

  logic [PRIO_W-1:0] n_prio, w_prio;
  logic              wants, toggle;
  logic [CW-1:0]     south_rt, east_rt;

  assign n_prio = north_i[P_HI -: PRIO_W];
  assign w_prio = west_i[P_HI -: PRIO_W];

  // west wins only with a strictly better (lower) priority value
  assign wants = west_i[V_BIT] & west_i[G_BIT] & (~north_i[V_BIT] | (n_prio > w_prio));

  always_comb begin
    toggle = wants;
    unique case (fault_i)
      FLT_XSTUCK: toggle = 1'b0;
      FLT_TSTUCK: toggle = 1'b1;
      default:    toggle = wants;
    endcase
    if (force_cross_i) toggle = 1'b0;
  end

  assign south_rt = toggle ? west_i  : north_i;
  assign east_rt  = toggle ? north_i : west_i;

  always_comb begin
    south_o = south_rt;
    east_o  = east_rt;
    unique case (fault_i)
      FLT_V_LO: south_o = '0;
      FLT_V_HI: south_o = '1;
      FLT_H_LO: east_o  = '0;
      FLT_H_HI: east_o  = '1;
      default: ;
    endcase
  end

endmodule

// File: rtl/cse_grid.sv
module cse_grid
  import cse_pkg::*;
#(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned COLS   = 3,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned CW    = 2 + PRIO_W + DATA_W,
  localparam int unsigned NEL   = ROWS * COLS
) (
  input  logic [ROWS*CW-1:0]      west_i,
  input  logic [COLS*CW-1:0]      north_i,
  input  logic [NEL-1:0]          force_cross_i,
  input  logic [NEL*FAULT_W-1:0]  fault_code_i,
  output logic [COLS*CW-1:0]      south_o,
  output logic [ROWS*CW-1:0]      east_o
);

  logic [CW-1:0] v_link [ROWS+1][COLS];
  logic [CW-1:0] h_link [ROWS][COLS+1];

  for (genvar c = 0; c < COLS; c++) begin : g_col_io
    assign v_link[0][c]          = north_i[c*CW +: CW];
    assign south_o[c*CW +: CW]   = v_link[ROWS][c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row_io
    assign h_link[r][0]          = west_i[r*CW +: CW];
    assign east_o[r*CW +: CW]    = h_link[r][COLS];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_cell
      localparam int unsigned IDX = r * COLS + c;
      cse_elem #(
        .PRIO_W (PRIO_W),
        .DATA_W (DATA_W)
      ) u_elem (
        .north_i       (v_link[r][c]),
        .west_i        (h_link[r][c]),
        .force_cross_i (force_cross_i[IDX]),
        .fault_i       (fault_e'(fault_code_i[IDX*FAULT_W +: FAULT_W])),
        .south_o       (v_link[r+1][c]),
        .east_o        (h_link[r][c+1])
      );
    end
  end

endmodule

// File: rtl/cse_out_reg.sv
module cse_out_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

endmodule

// File: rtl/cse_array.sv
module cse_array
  import cse_pkg::*;
#(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned COLS   = 3,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned CW    = 2 + PRIO_W + DATA_W,
  localparam int unsigned NEL   = ROWS * COLS,
  localparam int unsigned OUT_W = (ROWS + COLS) * CW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ROWS*CW-1:0]     west_i,
  input  logic [COLS*CW-1:0]     north_i,
  input  logic [NEL-1:0]         force_cross_i,
  input  logic [NEL*FAULT_W-1:0] fault_code_i,
  output logic [COLS*CW-1:0]     south_o,
  output logic [ROWS*CW-1:0]     east_o
);

  logic [COLS*CW-1:0] south_nx;
  logic [ROWS*CW-1:0] east_nx;

  cse_grid #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .PRIO_W (PRIO_W),
    .DATA_W (DATA_W)
  ) u_grid (
    .west_i        (west_i),
    .north_i       (north_i),
    .force_cross_i (force_cross_i),
    .fault_code_i  (fault_code_i),
    .south_o       (south_nx),
    .east_o        (east_nx)
  );

  cse_out_reg #(
    .WIDTH (OUT_W)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({east_nx, south_nx}),
    .q_o    ({east_o, south_o})
  );

  // ---------------- assertions ----------------
  logic              live_q;
  logic              any_fault, any_link_fault;
  logic [ROWS-1:0]   w_valid, w_grp, e_valid;
  logic [COLS-1:0]   n_valid, s_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  always_comb begin
    any_fault      = 1'b0;
    any_link_fault = 1'b0;
    for (int k = 0; k < NEL; k++) begin
      if (fault_code_i[k*FAULT_W +: FAULT_W] inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6})
        any_fault = 1'b1;
      if (fault_code_i[k*FAULT_W +: FAULT_W] inside {3'd3, 3'd4, 3'd5, 3'd6})
        any_link_fault = 1'b1;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rv
    assign w_valid[r] = west_i[r*CW + CW - 1];
    assign w_grp[r]   = west_i[r*CW + CW - 2];
    assign e_valid[r] = east_o[r*CW + CW - 1];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_cv
    assign n_valid[c] = north_i[c*CW + CW - 1];
    assign s_valid[c] = south_o[c*CW + CW - 1];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (south_o == '0 && east_o == '0)); // R1

  AST_CELL_CONSERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!any_fault)) |->
      ($countones(s_valid) + $countones(e_valid) ==
       $past($countones(w_valid) + $countones(n_valid)))); // R5

  AST_TEST_MODE_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!any_fault) && $past(w_grp == '0)) |->
      (south_o == $past(north_i) && east_o == $past(west_i))); // R6

  AST_FORCE_ALL_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!any_link_fault) && $past(&force_cross_i)) |->
      (south_o == $past(north_i) && east_o == $past(west_i))); // R7

endmodule

// File: tb/cse_array_tb_top.sv
module cse_array_tb_top;
  localparam int unsigned ROWS   = 4;
  localparam int unsigned COLS   = 3;
  localparam int unsigned PRIO_W = 2;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned CW     = 2 + PRIO_W + DATA_W;
  localparam int unsigned NEL    = ROWS * COLS;
  localparam int unsigned CLK_PERIOD = 10;

  logic                 clk = 1'b0;
  logic                 rst_ni;
  logic [ROWS*CW-1:0]   west_d;
  logic [COLS*CW-1:0]   north_d;
  logic [NEL-1:0]       fc_d;
  logic [NEL*3-1:0]     fl_d;
  logic [COLS*CW-1:0]   south_o;
  logic [ROWS*CW-1:0]   east_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  cse_array #(
    .ROWS(ROWS), .COLS(COLS), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .west_i(west_d), .north_i(north_d),
    .force_cross_i(fc_d), .fault_code_i(fl_d), .south_o(south_o), .east_o(east_o)
  );

  function automatic int unsigned nxt(input int unsigned s);
    int unsigned x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // slot-level reference walk built from the requirements
  task automatic ref_route(output logic [COLS*CW-1:0] s, output logic [ROWS*CW-1:0] e);
    logic [CW-1:0] col [COLS];
    for (int c = 0; c < COLS; c++) col[c] = north_d[c*CW +: CW];
    for (int r = 0; r < ROWS; r++) begin
      logic [CW-1:0] h = west_d[r*CW +: CW];
      for (int c = 0; c < COLS; c++) begin
        logic [CW-1:0] n = col[c];
        int k = r*COLS + c;
        int code = int'(fl_d[k*3 +: 3]);
        bit tog = h[CW-1] && h[CW-2] &&
                  (!n[CW-1] || (n[CW-3 -: PRIO_W] > h[CW-3 -: PRIO_W]));
        logic [CW-1:0] so, eo;
        if (code == 1) tog = 0;
        if (code == 2) tog = 1;
        if (fc_d[k]) tog = 0;
        so = tog ? h : n;
        eo = tog ? n : h;
        if (code == 3) so = '0;
        if (code == 4) so = '1;
        if (code == 5) eo = '0;
        if (code == 6) eo = '1;
        col[c] = so;
        h = eo;
      end
      e[r*CW +: CW] = h;
    end
    for (int c = 0; c < COLS; c++) s[c*CW +: CW] = col[c];
  endtask

  task automatic run_vec(input string req);
    logic [COLS*CW-1:0] es;
    logic [ROWS*CW-1:0] ee;
    ref_route(es, ee);
    @(posedge clk); #1;
    check(req, "south", 64'(south_o), 64'(es));
    check(req, "east",  64'(east_o),  64'(ee));
  endtask

  task automatic rnd_cells();
    seed = nxt(seed); west_d  = seed[ROWS*CW-1:0];
    seed = nxt(seed); north_d = seed[COLS*CW-1:0];
  endtask

  function automatic int vcount(input logic [63:0] v, input int n);
    int k = 0;
    for (int i = 0; i < n; i++) k += int'(v[i*CW + CW - 1]);
    return k;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; west_d = '0; north_d = '0; fc_d = '0; fl_d = '0;
    @(posedge clk); #1;
    check("R1", "south in reset", 64'(south_o), 64'd0);
    check("R1", "east in reset",  64'(east_o),  64'd0);
    west_d = '1; north_d = '1;
    @(posedge clk); #1;
    check("R1", "south in reset, busy inputs", 64'(south_o), 64'd0);
    check("R1", "east in reset, busy inputs",  64'(east_o),  64'd0);
    west_d = '0; north_d = '0;
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;

    // R3 tie: north keeps column 0, west cell turns down column 1
    north_d = '0; west_d = '0;
    north_d[0*CW +: CW] = 8'h9A;
    west_d[0*CW +: CW]  = 8'hD5;
    #(CLK_PERIOD/2 - 1);
    check("R4", "south before edge", 64'(south_o), 64'd0);
    @(posedge clk); #1;
    check("R3", "south tie", 64'(south_o), 64'({8'h00, 8'hD5, 8'h9A}));
    check("R3", "east tie",  64'(east_o),  64'd0);

    // R2 west outranks north; displaced group-0 cell exits east of row 0
    north_d[0*CW +: CW] = 8'hAA;
    @(posedge clk); #1;
    check("R2", "south win", 64'(south_o), 64'({8'h00, 8'h00, 8'hD5}));
    check("R2", "east win",  64'(east_o),  64'({8'h00, 8'h00, 8'h00, 8'hAA}));

    // R2 / R5 random fault-free sweep
    for (int i = 0; i < 300; i++) begin
      int cin;
      rnd_cells();
      cin = vcount(64'(west_d), ROWS) + vcount(64'(north_d), COLS);
      run_vec("R2");
      check("R5", "valid count",
            64'(vcount(64'(south_o), COLS) + vcount(64'(east_o), ROWS)), 64'(cin));
    end

    // R6 test mode: all west cells group 0
    for (int i = 0; i < 100; i++) begin
      logic [COLS*CW-1:0] nn;
      logic [ROWS*CW-1:0] ww;
      rnd_cells();
      for (int r = 0; r < ROWS; r++) west_d[r*CW + CW - 2] = 1'b0;
      nn = north_d; ww = west_d;
      @(posedge clk); #1;
      check("R6", "south test mode", 64'(south_o), 64'(nn));
      check("R6", "east test mode",  64'(east_o),  64'(ww));
    end

    // R7 full force-cross over toggle-stuck everywhere
    for (int i = 0; i < 40; i++) begin
      logic [COLS*CW-1:0] nn;
      logic [ROWS*CW-1:0] ww;
      rnd_cells();
      fc_d = '1;
      for (int k = 0; k < NEL; k++) fl_d[k*3 +: 3] = 3'd2;
      nn = north_d; ww = west_d;
      @(posedge clk); #1;
      check("R7", "south forced", 64'(south_o), 64'(nn));
      check("R7", "east forced",  64'(east_o),  64'(ww));
    end
    fl_d = '0;

    // R7 partial random force masks
    for (int i = 0; i < 100; i++) begin
      rnd_cells();
      seed = nxt(seed); fc_d = seed[NEL-1:0];
      run_vec("R7");
    end
    fc_d = '0;

    // R8..R12 single-element fault sweep
    for (int k = 0; k < NEL; k++) begin
      for (int code = 1; code < 8; code++) begin
        for (int i = 0; i < 6; i++) begin
          string req;
          rnd_cells();
          fl_d = '0;
          fl_d[k*3 +: 3] = 3'(code);
          case (code)
            1: req = "R8";
            2: req = "R9";
            3, 4: req = "R10";
            5, 6: req = "R11";
            default: req = "R12";
          endcase
          run_vec(req);
        end
      end
    end

    // R9 toggle-stuck with empty west: element (0,0) pulls the column-0 top cell east
    fl_d = '0; fl_d[0 +: 3] = 3'd2;
    west_d = '0; north_d = '0;
    north_d[0*CW +: CW] = 8'h2C;
    @(posedge clk); #1;
    check("R9", "south empty west", 64'(south_o), 64'd0);
    check("R9", "east empty west",  64'(east_o),  64'({8'h00, 8'h00, 8'h00, 8'h2C}));

    // R10 vertical stuck-at-1 on bottom element of column 1
    fl_d = '0; fl_d[((ROWS-1)*COLS+1)*3 +: 3] = 3'd4;
    west_d = '0; north_d = '0;
    @(posedge clk); #1;
    check("R10", "south stuck hi", 64'(south_o), 64'({8'h00, 8'hFF, 8'h00}));

    // R11 horizontal stuck-at-1 on last element of row 2
    fl_d = '0; fl_d[(2*COLS+COLS-1)*3 +: 3] = 3'd6;
    @(posedge clk); #1;
    check("R11", "east stuck hi", 64'(east_o), 64'({8'h00, 8'hFF, 8'h00, 8'h00}));

    // R12 spare code 7 everywhere behaves as fault-free test mode
    for (int k = 0; k < NEL; k++) fl_d[k*3 +: 3] = 3'd7;
    west_d = {8'h35, 8'h8F, 8'h00, 8'h81};
    north_d = {8'hC3, 8'h00, 8'h92};
    @(posedge clk); #1;
    check("R12", "south spare", 64'(south_o), 64'({8'hC3, 8'h00, 8'h92}));
    check("R12", "east spare",  64'(east_o),  64'({8'h35, 8'h8F, 8'h00, 8'h81}));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule